// File: doc/BRIEF.md
# Programmable Glitch Debounce Filter

This block conditions one already-synchronized input pin before it reaches interrupt or wake logic. It measures how long a new pin level has been held, counting in units made from a slow real-time-clock tick. The tick arrives as a single-cycle enable pulse from outside. A configuration of filter mode, timeout count and unit select decides whether the pin is passed through, fully debounced, or debounced in one direction only.

Qualification time is the timeout count times the selected unit. One of four units is selected: 2, 8, 512 or 2048 ticks. Three modes are available. Full debounce holds back every edge until it is stable. The two one-sided modes let short pulses toward a chosen level through at once and hold back only the return edge. When any configuration bit changes, the filter restarts and takes up the present pin level.

Top module: `pin_debounce`

## Requirements
- R1: With `cfgMode` = 0 (pass), `filtOut` equals the `pinIn` value of the previous clock and `busy` is low.
- R2: `{cfgLarge,cfgUnit}` selects the unit length in tick pulses: 00 gives 2, 01 gives 8, 10 gives 512 and 11 gives 2048.
- R3: With `cfgMode` = 1 (clean), a change of `pinIn` in either direction reaches `filtOut` only after the new level has been held for `cfgCount` units of ticks. The output updates at the clock edge that samples the final tick pulse.
- R4: With `cfgMode` = 2 (keep-low), a fall of `pinIn` reaches `filtOut` on the next clock. A rise is qualified as in R3.
- R5: With `cfgMode` = 3 (keep-high), a rise of `pinIn` reaches `filtOut` on the next clock. A fall is qualified as in R3.
- R6: If `pinIn` returns to the `filtOut` level before qualification ends, all progress is discarded. The next change needs the full time again.
- R7: A `cfgCount` of 0 in modes 1 to 3 qualifies after one unit.
- R8: A clock at which any of `cfgMode`, `cfgCount`, `cfgLarge` or `cfgUnit` differs from its previous value reloads `filtOut` with `pinIn` and restarts the timer.
- R9: `busy` is high exactly while a held-back transition is being timed: `pinIn` differs from `filtOut`, the mode is not pass, and the edge is not one that passes immediately.
- R10: While `rst_n` is low, `filtOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Single-cycle pulse, one per real-time-clock tick |
| pinIn | input | 1 | Synchronized pin level |
| cfgMode | input | 2 | 0 pass, 1 clean, 2 keep-low, 3 keep-high |
| cfgCount | input | 4 | Timeout count in units |
| cfgLarge | input | 1 | Unit select, high bit |
| cfgUnit | input | 1 | Unit select, low bit |
| filtOut | output | 1 | Filtered level |
| busy | output | 1 | A transition is being qualified |

## Verification
Some rules are checked by the assertions on every cycle. In pass mode the output is one clock behind the input. In the one-sided modes a preserved edge passes at the next clock. In clean mode the output holds in any cycle without a tick. A configuration change reloads the input level, and busy stays low in pass mode. The exact lengths cannot be seen by a one-cycle property: the number of ticks each unit select needs, the restart after a bounce, and count zero acting as one unit. The bench shows these by counting ticks in directed cases, and also compares every cycle of a long random run against a reference model.

// File: rtl/pd_pkg.sv
package pd_pkg;

  typedef enum logic [1:0] {
    MODE_PASS      = 2'd0,
    MODE_CLEAN     = 2'd1,
    MODE_KEEP_LOW  = 2'd2,
    MODE_KEEP_HIGH = 2'd3
  } filt_mode_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic clear;     // zero prescaler and unit counter
    logic stepPre;   // advance prescaler by one tick
    logic stepUnit;  // prescaler wrapped: bump unit counter
    logic load;      // load output register
    logic loadVal;   // value to load
  } dp_strobe_t;

endpackage

// File: rtl/pd_datapath.sv
module pd_datapath
  import pd_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int UNIT0_LOG2 = 1,
  parameter int UNIT1_LOG2 = 3,
  parameter int UNIT2_LOG2 = 9,
  parameter int UNIT3_LOG2 = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dp_strobe_t       strobe,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             cfgLarge,
  input  logic             cfgUnit,
  output logic             preLast,
  output logic             unitLast,
  output logic             filtOut
);

  localparam int PRE_W = UNIT3_LOG2;
  localparam logic [PRE_W-1:0] TOP0 = PRE_W'((1 << UNIT0_LOG2) - 1);
  localparam logic [PRE_W-1:0] TOP1 = PRE_W'((1 << UNIT1_LOG2) - 1);
  localparam logic [PRE_W-1:0] TOP2 = PRE_W'((1 << UNIT2_LOG2) - 1);
  localparam logic [PRE_W-1:0] TOP3 = PRE_W'((1 << UNIT3_LOG2) - 1);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] unitCnt;
  logic [PRE_W-1:0] preTop;
  logic [CNT_W-1:0] needM1;

  // unit select: large bit is the high bit of the selector
  always_comb begin
    unique case ({cfgLarge, cfgUnit})
      2'b00:   preTop = TOP0;
      2'b01:   preTop = TOP1;
      2'b10:   preTop = TOP2;
      default: preTop = TOP3;
    endcase
  end

  // a zero count still needs one unit
  assign needM1   = (cfgCount == '0) ? '0 : cfgCount - CNT_W'(1);
  assign preLast  = (preCnt == preTop);
  assign unitLast = (unitCnt == needM1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt  <= '0;
      unitCnt <= '0;
    end else if (strobe.clear) begin
      preCnt  <= '0;
      unitCnt <= '0;
    end else if (strobe.stepUnit) begin
      preCnt  <= '0;
      unitCnt <= unitCnt + CNT_W'(1);
    end else if (strobe.stepPre) begin
      preCnt  <= preCnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           filtOut <= 1'b0;
    else if (strobe.load) filtOut <= strobe.loadVal;
  end

endmodule

// File: rtl/pd_ctrl.sv
module pd_ctrl
  import pd_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             pinIn,
  input  logic [1:0]       cfgMode,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             cfgLarge,
  input  logic             cfgUnit,
  input  logic             filtOut,
  input  logic             preLast,
  input  logic             unitLast,
  output dp_strobe_t       strobe,
  output logic             busy
);

  localparam int CFG_W = 2 + CNT_W + 2;

  logic [CFG_W-1:0] cfgNow, cfgPrev;
  logic             cfgChg;
  logic             passNow;
  filt_mode_e       mode;

  assign cfgNow = {cfgMode, cfgCount, cfgLarge, cfgUnit};
  assign cfgChg = (cfgNow != cfgPrev);
  assign mode   = filt_mode_e'(cfgMode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfgPrev <= '0;
    else        cfgPrev <= cfgNow;
  end

  // edge toward the preserved level goes straight through
  always_comb begin
    unique case (mode)
      MODE_KEEP_LOW:  passNow = !pinIn;
      MODE_KEEP_HIGH: passNow = pinIn;
      default:        passNow = 1'b0;
    endcase
  end

  always_comb begin
    strobe  = '0;
    busy    = 1'b0;
    if (cfgChg || mode == MODE_PASS) begin
      strobe.clear   = 1'b1;
      strobe.load    = 1'b1;
      strobe.loadVal = pinIn;
    end else if (pinIn == filtOut) begin
      strobe.clear   = 1'b1;
    end else if (passNow) begin
      strobe.clear   = 1'b1;
      strobe.load    = 1'b1;
      strobe.loadVal = pinIn;
    end else begin
      busy = 1'b1;
      if (tickEn) begin
        if (preLast && unitLast) begin
          strobe.clear   = 1'b1;
          strobe.load    = 1'b1;
          strobe.loadVal = pinIn;
        end else if (preLast) begin
          strobe.stepUnit = 1'b1;
        end else begin
          strobe.stepPre  = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pin_debounce.sv
module pin_debounce
  import pd_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int UNIT0_LOG2 = 1,
  parameter int UNIT1_LOG2 = 3,
  parameter int UNIT2_LOG2 = 9,
  parameter int UNIT3_LOG2 = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             pinIn,
  input  logic [1:0]       cfgMode,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             cfgLarge,
  input  logic             cfgUnit,
  output logic             filtOut,
  output logic             busy
);

  dp_strobe_t strobe;
  logic       preLast;
  logic       unitLast;

  pd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tickEn   (tickEn),
    .pinIn    (pinIn),
    .cfgMode  (cfgMode),
    .cfgCount (cfgCount),
    .cfgLarge (cfgLarge),
    .cfgUnit  (cfgUnit),
    .filtOut  (filtOut),
    .preLast  (preLast),
    .unitLast (unitLast),
    .strobe   (strobe),
    .busy     (busy)
  );

  pd_datapath #(
    .CNT_W      (CNT_W),
    .UNIT0_LOG2 (UNIT0_LOG2),
    .UNIT1_LOG2 (UNIT1_LOG2),
    .UNIT2_LOG2 (UNIT2_LOG2),
    .UNIT3_LOG2 (UNIT3_LOG2)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .cfgCount (cfgCount),
    .cfgLarge (cfgLarge),
    .cfgUnit  (cfgUnit),
    .preLast  (preLast),
    .unitLast (unitLast),
    .filtOut  (filtOut)
  );

endmodule

// File: rtl/pd_checker.sv
module pd_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tickEn,
  input logic             pinIn,
  input logic [1:0]       cfgMode,
  input logic [CNT_W-1:0] cfgCount,
  input logic             cfgLarge,
  input logic             cfgUnit,
  input logic             filtOut,
  input logic             busy
);

  logic [CNT_W+3:0] cfgBus;
  logic             armed;

  assign cfgBus = {cfgMode, cfgCount, cfgLarge, cfgUnit};

  // armed once a full cycle since reset has passed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_pass_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfgMode == 2'd0 |=> filtOut == $past(pinIn));

  assert_pass_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfgMode == 2'd0 |-> !busy);

  assert_clean_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cfgMode == 2'd1 && !tickEn && $stable(cfgBus)) |=> $stable(filtOut));

  assert_keep_low_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cfgMode == 2'd2 && $stable(cfgBus) && !pinIn) |=> !filtOut);

  assert_keep_low_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cfgMode == 2'd2 && $stable(cfgBus) && !tickEn && !filtOut) |=> !filtOut);

  assert_keep_high_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cfgMode == 2'd3 && $stable(cfgBus) && pinIn) |=> filtOut);

  assert_keep_high_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cfgMode == 2'd3 && $stable(cfgBus) && !tickEn && filtOut) |=> filtOut);

  assert_cfg_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$stable(cfgBus)) |=> filtOut == $past(pinIn));

  assert_busy_differs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pinIn != filtOut);

  always_comb begin
    if (!rst_n) assert_reset_low_R10: assert (!filtOut);
  end

endmodule

bind pin_debounce pd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tickEn   (tickEn),
  .pinIn    (pinIn),
  .cfgMode  (cfgMode),
  .cfgCount (cfgCount),
  .cfgLarge (cfgLarge),
  .cfgUnit  (cfgUnit),
  .filtOut  (filtOut),
  .busy     (busy)
);

// File: tb/sim_pin_debounce.sv
`timescale 1ns/1ps
module sim_pin_debounce;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickEn = 1'b0;
  logic       pinIn = 1'b0;
  logic [1:0] cfgMode = 2'd0;
  logic [3:0] cfgCount = 4'd0;
  logic       cfgLarge = 1'b0;
  logic       cfgUnit = 1'b0;
  logic       filtOut;
  logic       busy;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pin_debounce u0 (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .pinIn(pinIn),
    .cfgMode(cfgMode), .cfgCount(cfgCount), .cfgLarge(cfgLarge),
    .cfgUnit(cfgUnit), .filtOut(filtOut), .busy(busy)
  );

  // ---------------- reference model from the requirements ----------------
  logic [7:0]  mPrevCfg;
  logic        mOut;
  int          mPre;
  int          mUnit;

  function automatic int unitTicks(logic l, logic u);  // R2
    case ({l, u})
      2'b00:   return 2;
      2'b01:   return 8;
      2'b10:   return 512;
      default: return 2048;
    endcase
  endfunction

  function automatic int needUnits(logic [3:0] c);     // R7
    return (c == 4'd0) ? 1 : int'(c);
  endfunction

  function automatic logic fastEdge(logic [1:0] m, logic p); // R4, R5
    return (m == 2'd2 && !p) || (m == 2'd3 && p);
  endfunction

  function automatic logic expBusy();                  // R9
    return ({cfgMode, cfgCount, cfgLarge, cfgUnit} == mPrevCfg) && cfgMode != 2'd0
           && pinIn != mOut && !fastEdge(cfgMode, pinIn);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mPrevCfg = '0; mOut = 1'b0; mPre = 0; mUnit = 0;
    end else begin
      logic chg;
      chg = ({cfgMode, cfgCount, cfgLarge, cfgUnit} != mPrevCfg);
      mPrevCfg = {cfgMode, cfgCount, cfgLarge, cfgUnit};
      if (chg || cfgMode == 2'd0) begin
        mOut = pinIn; mPre = 0; mUnit = 0;
      end else if (pinIn == mOut) begin
        mPre = 0; mUnit = 0;
      end else if (fastEdge(cfgMode, pinIn)) begin
        mOut = pinIn; mPre = 0; mUnit = 0;
      end else if (tickEn) begin
        if (mPre == unitTicks(cfgLarge, cfgUnit) - 1) begin
          mPre = 0;
          if (mUnit == needUnits(cfgCount) - 1) begin
            mOut = pinIn; mUnit = 0;
          end else mUnit = mUnit + 1;
        end else mPre = mPre + 1;
      end
    end
  end

  function automatic string modeTag(logic [1:0] m);
    case (m)
      2'd0: return "R1";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check({modeTag(cfgMode), " model out"}, filtOut, mOut);
      check("R9 model busy", busy, expBusy());
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic setCfg(logic [1:0] m, logic [3:0] c, logic l, logic u);
    cfgMode = m; cfgCount = c; cfgLarge = l; cfgUnit = u;
  endtask

  // drive newVal now; with a tick every cycle it must appear after n edges
  task automatic expectAfter(string tag, int n, logic newVal);
    tickEn = 1'b1;
    pinIn = newVal;
    repeat (n - 1) step();
    @(negedge clk);
    check({tag, " held before last tick"}, filtOut, !newVal);
    check({tag, " busy while timing"}, busy, 1'b1);
    step();
    @(negedge clk);
    check({tag, " updated on last tick"}, filtOut, newVal);
    check({tag, " busy cleared"}, busy, 1'b0);
    step();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset out", filtOut, 1'b0);
    check("R10 reset busy", busy, 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // clean mode, 3 units of 2 ticks, both directions (R3)
    setCfg(2'd1, 4'd3, 1'b0, 1'b0); pinIn = 1'b0;
    repeat (3) step();
    expectAfter("R3", 6, 1'b1);
    expectAfter("R3", 6, 1'b0);

    // unit selects (R2)
    setCfg(2'd1, 4'd1, 1'b0, 1'b1); repeat (3) step();
    expectAfter("R2 x8", 8, 1'b1);
    setCfg(2'd1, 4'd1, 1'b1, 1'b0); repeat (3) step();
    expectAfter("R2 x512", 512, 1'b0);
    setCfg(2'd1, 4'd1, 1'b1, 1'b1); repeat (3) step();
    expectAfter("R2 x2048", 2048, 1'b1);

    // zero count means one unit (R7)
    setCfg(2'd1, 4'd0, 1'b0, 1'b0); repeat (3) step();
    expectAfter("R7", 2, 1'b0);

    // bounce restarts qualification (R6)
    setCfg(2'd1, 4'd2, 1'b0, 1'b0); repeat (3) step();
    tickEn = 1'b1; pinIn = 1'b1;
    repeat (3) step();
    pinIn = 1'b0;
    step();
    @(negedge clk);
    check("R6 bounce out", filtOut, 1'b0);
    check("R6 bounce busy", busy, 1'b0);
    step();
    expectAfter("R6", 4, 1'b1);

    // keep-low mode (R4); config change reloads high (R8)
    setCfg(2'd2, 4'd5, 1'b0, 1'b0); tickEn = 1'b0;
    step();
    @(negedge clk);
    check("R8 reload high", filtOut, 1'b1);
    step();
    pinIn = 1'b0;
    step();
    @(negedge clk);
    check("R4 fall passes next clock", filtOut, 1'b0);
    step();
    pinIn = 1'b1;
    repeat (10) step();
    @(negedge clk);
    check("R4 rise held without ticks", filtOut, 1'b0);
    check("R9 busy while rise held", busy, 1'b1);
    step();
    expectAfter("R4", 10, 1'b1);

    // keep-high mode (R5)
    setCfg(2'd3, 4'd5, 1'b0, 1'b0); tickEn = 1'b0;
    repeat (2) step();
    pinIn = 1'b0;
    repeat (6) step();
    @(negedge clk);
    check("R5 fall held without ticks", filtOut, 1'b1);
    step();
    expectAfter("R5", 10, 1'b0);
    tickEn = 1'b0; pinIn = 1'b1;
    step();
    @(negedge clk);
    check("R5 rise passes next clock", filtOut, 1'b1);
    check("R9 no busy on passed edge", busy, 1'b0);
    step();

    // config change mid-qualification (R8)
    pinIn = 1'b0;
    setCfg(2'd1, 4'd15, 1'b1, 1'b1); tickEn = 1'b1;
    repeat (3) step();
    pinIn = 1'b1;
    repeat (20) step();
    @(negedge clk);
    check("R8 still timing", busy, 1'b1);
    step();
    setCfg(2'd1, 4'd14, 1'b1, 1'b1);
    step();
    @(negedge clk);
    check("R8 reload on change", filtOut, 1'b1);
    check("R8 busy after reload", busy, 1'b0);
    step();

    // pass mode (R1)
    setCfg(2'd0, 4'd9, 1'b0, 1'b0); tickEn = 1'b0;
    step();
    pinIn = 1'b0;
    step();
    @(negedge clk);
    check("R1 follows low", filtOut, 1'b0);
    step();
    pinIn = 1'b1;
    step();
    @(negedge clk);
    check("R1 follows high", filtOut, 1'b1);
    check("R1 never busy", busy, 1'b0);
    step();

    // constrained random phase, checked by the model
    for (int i = 0; i < 15000; i++) begin
      tickEn = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 5) == 0) pinIn = ~pinIn;
      if ($urandom_range(0, 299) == 0) begin
        cfgMode  = 2'($urandom_range(0, 3));
        cfgCount = 4'($urandom_range(0, 4));
        cfgLarge = ($urandom_range(0, 15) == 0);
        cfgUnit  = 1'($urandom_range(0, 1));
      end
      step();
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule